// File: doc/BRIEF.md
# Multiplexed Pixel Bus Unpacker

This block sits between a graphics controller's pixel bus and a video pipeline. The bus is up to 16 bits wide and may carry one word per pixel, or two or three narrower transfers per pixel. The block rebuilds each complete pixel and presents it as a 24-bit word with a one-cycle valid strobe. A format code selects the layout: 5-5-5 or 5-6-5 RGB, 8-8-8 RGB, and two YCbCr sequences in which chroma is shared between two luma samples. Narrow colour fields are widened to 8 bits by copying their top bits into the vacant low bits.

Transfers are captured on the rising edge of an internal capture clock, which is the input clock, optionally inverted. When the clock runs at the pixel rate and a two-transfer RGB format is chosen, double-rate capture can be enabled. The first transfer of a pixel is then taken on the capture clock's rising edge and the second on its falling edge. A control state machine has three states. IDLE waits for the first horizontal sync leading edge after reset. PORCH skips a programmable number of pixels, multiplied by the transfers per pixel. ACTIVE hands every transfer to the assembler until the next sync leading edge. A sync leading edge in any state causes the transition to PORCH, or straight to ACTIVE when the delay is zero. When the skip count is used up, PORCH makes the transition to ACTIVE. Each sync leading edge also clears the transfer-phase counter, so a dropped transfer affects at most one line.

Top module: `pix_unpacker`

## Requirements
- R1: After reset, `pix_out` is 0 and `pix_vld` is 0. No transfer is accepted until the first `hsync` leading edge. The transfer present at the capture edge where `hsync` is first seen high is never used as data.
- R2: Format 0 (one word per pixel, 5-6-5) gives R=bus[15:11], G=bus[10:5], B=bus[4:0]. Format 1 (5-5-5) gives R=bus[14:10], G=bus[9:5], B=bus[4:0]. The output is {R,G,B}, 8 bits each. A 5-bit field f widens to {f, f[4:2]} and a 6-bit field g widens to {g, g[5:4]}.
- R3: Formats 3 (5-5-5) and 4 (5-6-5) take two transfers on bus[7:0]. The first byte is the high byte of the word. The joined word is decoded as in R2, and bus[15:8] is ignored.
- R4: Format 5 takes three transfers on bus[7:0], carrying R, then G, then B. `pix_vld` pulses once for every three transfers.
- R5: Format 7 gives {first[11:0], second[11:0]}. Format 8 gives R={a[11:8],b[11:8]}, G={a[7:4],b[7:4]} and B={a[3:0],b[3:0]}, where a is the first transfer and b the second. Format 9 gives {first[15:0], second[15:8]}.
- R6: Format 2 takes one word per transfer. Word pairs arrive as {Cb,Y0} and then {Cr,Y1}, with chroma in bits [15:8]. On the second word the output is {Y0,Cb,Cr}. On the following cycle the output is {Y1,Cb,Cr}.
- R7: Format 6 takes bytes on bus[7:0] in the repeating order Cb, Y0, Cr, Y1. The output is {Y0,Cb,Cr} on Cr and {Y1,Cb,Cr} on Y1, with no strobe on Cb or Y0.
- R8: After a sync leading edge, exactly `cfg_delay` multiplied by the transfers per pixel are skipped before capture. The transfers per pixel are 1 for formats 0 to 2, 3 for format 5, and 2 for the others.
- R9: A sync leading edge resets the transfer phase, so a partial pixel from before the edge is discarded.
- R10: With `cfg_ddr`=1 and format 3, 4, 7, 8 or 9, each capture cycle takes its first transfer on the rising edge and its second on the following falling edge. The pixel is presented at the next rising edge. For any other format, `cfg_ddr` has no effect.
- R11: With `cfg_inv`=1, all capture and output updates happen on the falling edge of `clk`.
- R12: Format codes 10 to 15 never raise `pix_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Bus format code (0 to 9) |
| cfg_inv | input | 1 | Invert the capture clock |
| cfg_ddr | input | 1 | Capture on both edges for two-transfer RGB formats |
| cfg_delay | input | DLY_W | Pixels skipped after sync leading edge |
| hsync | input | 1 | Horizontal sync, leading edge is rising |
| bus_in | input | 16 | Pixel transfer bus |
| pix_out | output | 24 | Assembled pixel, {R,G,B} or {Y,Cb,Cr} |
| pix_vld | output | 1 | One-cycle strobe marking a new pixel |

## Verification
The bench builds the block with `DLY_W` = 4. A delay of 15 is then the largest value the field can hold. With the three-transfer format, that value makes the skip counter run through its widest range of 45 transfers in a short run. A vector table covers every RGB layout, using byte values chosen so that widening, byte order and the ignored upper lanes each give a distinct result. Directed sequences cover:
- both chroma-sharing orders;
- a partial pixel cut off by a sync edge;
- double-rate capture, and that capture being ignored for the three-transfer format;
- the inverted clock;
- the unused format codes.

// File: rtl/pixunp_pkg.sv
package pixunp_pkg;

    localparam int BUS_W = 16;
    localparam int PIX_W = 24;

    localparam logic [3:0] FMT_W565   = 4'd0;
    localparam logic [3:0] FMT_W555   = 4'd1;
    localparam logic [3:0] FMT_YC16   = 4'd2;
    localparam logic [3:0] FMT_B555   = 4'd3;
    localparam logic [3:0] FMT_B565   = 4'd4;
    localparam logic [3:0] FMT_B888   = 4'd5;
    localparam logic [3:0] FMT_YC8    = 4'd6;
    localparam logic [3:0] FMT_N12C   = 4'd7;
    localparam logic [3:0] FMT_N12I   = 4'd8;
    localparam logic [3:0] FMT_W16X2  = 4'd9;
    localparam logic [3:0] FMT_COUNT  = 4'd10;

    function automatic logic [7:0] widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] g);
        return {g, g[5:4]};
    endfunction

    function automatic logic [1:0] xfers_per_pixel(input logic [3:0] fmt);
        case (fmt)
            FMT_W565, FMT_W555, FMT_YC16: return 2'd1;
            FMT_B888:                     return 2'd3;
            FMT_B555, FMT_B565, FMT_YC8,
            FMT_N12C, FMT_N12I, FMT_W16X2: return 2'd2;
            default:                      return 2'd1;
        endcase
    endfunction

    function automatic logic ddr_capable(input logic [3:0] fmt);
        return (fmt == FMT_B555) || (fmt == FMT_B565) || (fmt == FMT_N12C) ||
               (fmt == FMT_N12I) || (fmt == FMT_W16X2);
    endfunction

    // a: first transfer, b: second, c: third (byte lane only)
    function automatic logic [PIX_W-1:0] unpack_rgb(input logic [3:0] fmt,
                                                    input logic [BUS_W-1:0] a,
                                                    input logic [BUS_W-1:0] b,
                                                    input logic [7:0] c);
        logic [15:0] joined;
        joined = {a[7:0], b[7:0]};
        case (fmt)
            FMT_W565:  return {widen5(a[15:11]), widen6(a[10:5]), widen5(a[4:0])};
            FMT_W555:  return {widen5(a[14:10]), widen5(a[9:5]), widen5(a[4:0])};
            FMT_B565:  return {widen5(joined[15:11]), widen6(joined[10:5]), widen5(joined[4:0])};
            FMT_B555:  return {widen5(joined[14:10]), widen5(joined[9:5]), widen5(joined[4:0])};
            FMT_B888:  return {a[7:0], b[7:0], c};
            FMT_N12C:  return {a[11:0], b[11:0]};
            FMT_N12I:  return {a[11:8], b[11:8], a[7:4], b[7:4], a[3:0], b[3:0]};
            FMT_W16X2: return {a, b[15:8]};
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/pixunp_ctrl.sv
module pixunp_ctrl #(
    parameter int DLY_W = 10
) (
    input  logic             cclk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic [DLY_W-1:0] delay,
    input  logic [1:0]       mux,
    input  logic             ddr_eff,
    output logic             take,
    output logic             line_start
);

    localparam int CNT_W = DLY_W + 2;

    typedef enum logic [1:0] {ST_IDLE, ST_PORCH, ST_ACTIVE} st_e;

    st_e              state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hs_q;
    logic             hs_lead;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] step;

    assign hs_lead = hsync & ~hs_q;
    assign total   = CNT_W'(delay) * CNT_W'(mux);
    assign step    = ddr_eff ? CNT_W'(2) : CNT_W'(1);

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            hs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hs_q    <= hsync;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (hs_lead) begin
            state_d = (total == '0) ? ST_ACTIVE : ST_PORCH;
            cnt_d   = total;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_PORCH: begin
                    if (cnt_q <= step) begin
                        state_d = ST_ACTIVE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - step;
                    end
                end
                ST_ACTIVE: state_d = ST_ACTIVE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        line_start = hs_lead;
        take       = (state_q == ST_ACTIVE) && !hs_lead;
    end

    assert_porch_entry_R8: assert property (@(posedge cclk) disable iff (!rst_n)
        (hs_lead && total != '0) |=> (state_q == ST_PORCH));

endmodule

// File: rtl/pixunp_asm.sv
module pixunp_asm
    import pixunp_pkg::*;
(
    input  logic             cclk,
    input  logic             rst_n,
    input  logic [3:0]       fmt,
    input  logic             ddr_eff,
    input  logic             take,
    input  logic             line_start,
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] fall_word,
    output logic [PIX_W-1:0] pix,
    output logic             vld
);

    logic [1:0]       ph_q;
    logic [BUS_W-1:0] w0_q;
    logic [7:0]       w1_q;
    logic [BUS_W-1:0] rise_q;
    logic             arm_q;
    logic [7:0]       y_q, cb_q, cr_q, pend_y_q;
    logic             pend_q;
    logic [PIX_W-1:0] pix_q;
    logic             vld_q;

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q     <= '0;
            w0_q     <= '0;
            w1_q     <= '0;
            rise_q   <= '0;
            arm_q    <= 1'b0;
            y_q      <= '0;
            cb_q     <= '0;
            cr_q     <= '0;
            pend_y_q <= '0;
            pend_q   <= 1'b0;
            pix_q    <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            pend_q <= 1'b0;
            if (line_start) ph_q <= '0;

            // double-rate pair completes one edge after its rising capture
            if (arm_q && ddr_eff) begin
                vld_q <= 1'b1;
                pix_q <= unpack_rgb(fmt, rise_q, fall_word, 8'h00);
            end
            arm_q <= ddr_eff && take;
            if (ddr_eff && take) rise_q <= bus;

            // second luma of a shared-chroma word pair
            if (pend_q && fmt == FMT_YC16) begin
                vld_q <= 1'b1;
                pix_q <= {pend_y_q, cb_q, cr_q};
            end

            if (take && !ddr_eff) begin
                unique case (fmt)
                    FMT_W565, FMT_W555: begin
                        vld_q <= 1'b1;
                        pix_q <= unpack_rgb(fmt, bus, '0, 8'h00);
                    end
                    FMT_YC16: begin
                        if (ph_q == 2'd0) begin
                            cb_q <= bus[15:8];
                            y_q  <= bus[7:0];
                            ph_q <= 2'd1;
                        end else begin
                            vld_q    <= 1'b1;
                            pix_q    <= {y_q, cb_q, bus[15:8]};
                            cr_q     <= bus[15:8];
                            pend_y_q <= bus[7:0];
                            pend_q   <= 1'b1;
                            ph_q     <= 2'd0;
                        end
                    end
                    FMT_YC8: begin
                        unique case (ph_q)
                            2'd0: cb_q <= bus[7:0];
                            2'd1: y_q  <= bus[7:0];
                            2'd2: begin
                                cr_q  <= bus[7:0];
                                vld_q <= 1'b1;
                                pix_q <= {y_q, cb_q, bus[7:0]};
                            end
                            2'd3: begin
                                vld_q <= 1'b1;
                                pix_q <= {bus[7:0], cb_q, cr_q};
                            end
                            default: ;
                        endcase
                        ph_q <= ph_q + 2'd1;
                    end
                    FMT_B888: begin
                        unique case (ph_q)
                            2'd0: begin w0_q <= bus; ph_q <= 2'd1; end
                            2'd1: begin w1_q <= bus[7:0]; ph_q <= 2'd2; end
                            default: begin
                                vld_q <= 1'b1;
                                pix_q <= unpack_rgb(fmt, w0_q, {8'h00, w1_q}, bus[7:0]);
                                ph_q  <= 2'd0;
                            end
                        endcase
                    end
                    FMT_B555, FMT_B565, FMT_N12C, FMT_N12I, FMT_W16X2: begin
                        if (ph_q == 2'd0) begin
                            w0_q <= bus;
                            ph_q <= 2'd1;
                        end else begin
                            vld_q <= 1'b1;
                            pix_q <= unpack_rgb(fmt, w0_q, bus, 8'h00);
                            ph_q  <= 2'd0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pix = pix_q;
    assign vld = vld_q;

    assert_phase_reset_R9: assert property (@(posedge cclk) disable iff (!rst_n)
        line_start |=> (ph_q == 2'd0));

    assert_three_xfer_gap_R4: assert property (@(posedge cclk) disable iff (!rst_n)
        (vld_q && fmt == FMT_B888 && $stable(fmt)) |=> !vld_q);

    assert_bad_fmt_quiet_R12: assert property (@(posedge cclk) disable iff (!rst_n)
        (fmt >= FMT_COUNT && $stable(fmt)) |-> !vld_q);

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
    import pixunp_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_fmt,
    input  logic             cfg_inv,
    input  logic             cfg_ddr,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic             hsync,
    input  logic [15:0]      bus_in,
    output logic [23:0]      pix_out,
    output logic             pix_vld
);

    logic             cclk;
    logic             ddr_eff;
    logic [1:0]       mux;
    logic             take;
    logic             line_start;
    logic [BUS_W-1:0] fall_q;

    assign cclk    = clk ^ cfg_inv;
    assign ddr_eff = cfg_ddr && ddr_capable(cfg_fmt);
    assign mux     = xfers_per_pixel(cfg_fmt);

    always_ff @(negedge cclk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= bus_in;
    end

    pixunp_ctrl #(.DLY_W(DLY_W)) ctrl_i (
        .cclk       (cclk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .delay      (cfg_delay),
        .mux        (mux),
        .ddr_eff    (ddr_eff),
        .take       (take),
        .line_start (line_start)
    );

    pixunp_asm asm_i (
        .cclk       (cclk),
        .rst_n      (rst_n),
        .fmt        (cfg_fmt),
        .ddr_eff    (ddr_eff),
        .take       (take),
        .line_start (line_start),
        .bus        (bus_in),
        .fall_word  (fall_q),
        .pix        (pix_out),
        .vld        (pix_vld)
    );

endmodule

// File: tb/pix_unpacker_tb_top.sv
module pix_unpacker_tb_top;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    cfg_fmt = 4'd0;
    logic          cfg_inv = 1'b0;
    logic          cfg_ddr = 1'b0;
    logic [DW-1:0] cfg_delay = '0;
    logic          hsync = 1'b0;
    logic [15:0]   bus_in = '0;
    logic [23:0]   pix_out;
    logic          pix_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pix_unpacker #(.DLY_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_inv(cfg_inv),
        .cfg_ddr(cfg_ddr), .cfg_delay(cfg_delay), .hsync(hsync),
        .bus_in(bus_in), .pix_out(pix_out), .pix_vld(pix_vld)
    );

    // {fmt, w0, w1, w2, expected}
    localparam logic [75:0] VEC [8] = '{
        {4'd0, 16'h8410, 16'h0000, 16'h0000, 24'h848284},
        {4'd1, 16'h2A55, 16'h0000, 16'h0000, 24'h5294AD},
        {4'd3, 16'hFF2A, 16'hAA55, 16'h0000, 24'h5294AD},
        {4'd4, 16'h1284, 16'h3410, 16'h0000, 24'h848284},
        {4'd5, 16'hFF12, 16'h0034, 16'h0056, 24'h123456},
        {4'd7, 16'hF123, 16'hF456, 16'h0000, 24'h123456},
        {4'd8, 16'h0135, 16'h0246, 16'h0000, 24'h123456},
        {4'd9, 16'hABCD, 16'hEF77, 16'h0000, 24'hABCDEF}
    };

    task automatic check(input string req, input logic [23:0] exp_pix, input logic exp_v);
        n_chk++;
        if (pix_vld !== exp_v || (exp_v && pix_out !== exp_pix)) begin
            n_bad++;
            $display("FAIL %s: vld=%0b pix=%06h expected vld=%0b pix=%06h",
                     req, pix_vld, pix_out, exp_v, exp_pix);
        end
    endtask

    task automatic cap_edge();
        if (cfg_inv) @(negedge clk);
        else         @(posedge clk);
    endtask

    task automatic step(input logic [15:0] w, input logic hs);
        bus_in = w;
        hsync  = hs;
        cap_edge();
        #5;
    endtask

    task automatic pair(input logic [15:0] a, input logic [15:0] b);
        bus_in = a;
        hsync  = 1'b0;
        cap_edge();
        #5;
        bus_in = b;
        #10;
    endtask

    task automatic start(input logic [3:0] f, input logic inv, input logic ddr,
                         input logic [DW-1:0] dly, input logic do_hs);
        rst_n     = 1'b0;
        cfg_fmt   = f;
        cfg_inv   = inv;
        cfg_ddr   = ddr;
        cfg_delay = dly;
        hsync     = 1'b0;
        bus_in    = '0;
        #40;
        cap_edge();
        #5;
        rst_n = 1'b1;
        if (do_hs) step(16'h0000, 1'b1);
    endtask

    function automatic int nxfer(input logic [3:0] f);
        if (f <= 4'd2) return 1;
        if (f == 4'd5) return 3;
        return 2;
    endfunction

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state, and no capture before the first sync edge
        start(4'd0, 1'b0, 1'b0, '0, 1'b0);
        check("R1 reset", 24'h0, 1'b0);
        step(16'h8410, 1'b0);
        check("R1 no capture before hsync", 24'h0, 1'b0);

        // R2 R3 R4 R5: layout table
        for (int i = 0; i < 8; i++) begin
            logic [75:0] v;
            int n;
            v = VEC[i];
            start(v[75:72], 1'b0, 1'b0, '0, 1'b1);
            n = nxfer(v[75:72]);
            step(v[71:56], 1'b0);
            if (n >= 2) begin
                check("R4 R5 no strobe mid pixel", 24'h0, 1'b0);
                step(v[55:40], 1'b0);
            end
            if (n == 3) step(v[39:24], 1'b0);
            check("R2 R3 R4 R5 layout", v[23:0], 1'b1);
            step(16'h0000, 1'b0);
            if (n == 3) check("R4 single strobe per three", 24'h0, 1'b0);
        end

        // R8: porch skip in a two-transfer format
        begin
            int seen;
            seen = 0;
            start(4'd3, 1'b0, 1'b0, 4'd2, 1'b1);
            for (int k = 0; k < 4; k++) begin
                step(16'h00FF, 1'b0);
                if (pix_vld) seen++;
            end
            n_chk++;
            if (seen != 0) begin
                n_bad++;
                $display("FAIL R8 strobe in porch: actual %0d expected 0", seen);
            end
            step(16'h002A, 1'b0);
            step(16'h0055, 1'b0);
            check("R8 first pixel after porch", 24'h5294AD, 1'b1);
        end

        // R8: largest delay with three transfers per pixel (45 skipped)
        begin
            int seen;
            seen = 0;
            start(4'd5, 1'b0, 1'b0, 4'd15, 1'b1);
            for (int k = 0; k < 45; k++) begin
                step(16'h00EE, 1'b0);
                if (pix_vld) seen++;
            end
            n_chk++;
            if (seen != 0) begin
                n_bad++;
                $display("FAIL R8 strobe in long porch: actual %0d expected 0", seen);
            end
            step(16'h0012, 1'b0);
            step(16'h0034, 1'b0);
            step(16'h0056, 1'b0);
            check("R8 pixel after 45 skipped", 24'h123456, 1'b1);
        end

        // R9: a partial pixel is dropped at the sync edge
        start(4'd5, 1'b0, 1'b0, '0, 1'b1);
        step(16'h0099, 1'b0);
        step(16'h0000, 1'b1);
        step(16'h0012, 1'b0);
        step(16'h0034, 1'b0);
        step(16'h0056, 1'b0);
        check("R9 phase realigned", 24'h123456, 1'b1);

        // R6: word-wide shared chroma
        start(4'd2, 1'b0, 1'b0, '0, 1'b1);
        step(16'h10A0, 1'b0);
        check("R6 first word no strobe", 24'h0, 1'b0);
        step(16'h20B0, 1'b0);
        check("R6 Y0", 24'hA01020, 1'b1);
        step(16'h30C0, 1'b0);
        check("R6 Y1 held chroma", 24'hB01020, 1'b1);
        step(16'h40D0, 1'b0);
        check("R6 Y2", 24'hC03040, 1'b1);
        step(16'h0000, 1'b0);
        check("R6 Y3", 24'hD03040, 1'b1);

        // R7: byte-wide shared chroma
        start(4'd6, 1'b0, 1'b0, '0, 1'b1);
        step(16'h0011, 1'b0);
        check("R7 Cb no strobe", 24'h0, 1'b0);
        step(16'h0022, 1'b0);
        check("R7 Y0 no strobe", 24'h0, 1'b0);
        step(16'h0033, 1'b0);
        check("R7 on Cr", 24'h221133, 1'b1);
        step(16'h0044, 1'b0);
        check("R7 on Y1", 24'h441133, 1'b1);

        // R10: double-rate capture
        start(4'd7, 1'b0, 1'b1, '0, 1'b1);
        pair(16'h0123, 16'h0456);
        check("R10 no strobe before pair done", 24'h0, 1'b0);
        pair(16'h0789, 16'h0ABC);
        check("R10 first pair", 24'h123456, 1'b1);
        pair(16'h0000, 16'h0000);
        check("R10 second pair", 24'h789ABC, 1'b1);

        // R10: double rate has no effect on the three-transfer format
        start(4'd5, 1'b0, 1'b1, '0, 1'b1);
        step(16'h0012, 1'b0);
        step(16'h0034, 1'b0);
        step(16'h0056, 1'b0);
        check("R10 ignored for format 5", 24'h123456, 1'b1);

        // R11: inverted capture clock
        start(4'd0, 1'b1, 1'b0, '0, 1'b1);
        step(16'h8410, 1'b0);
        check("R11 inverted single word", 24'h848284, 1'b1);
        start(4'd3, 1'b1, 1'b0, '0, 1'b1);
        step(16'h002A, 1'b0);
        step(16'h0055, 1'b0);
        check("R11 inverted two bytes", 24'h5294AD, 1'b1);

        // R12: unused format code
        begin
            int seen;
            seen = 0;
            start(4'd12, 1'b0, 1'b0, '0, 1'b1);
            for (int k = 0; k < 6; k++) begin
                step(16'h1234 + 16'(k), 1'b0);
                if (pix_vld) seen++;
            end
            n_chk++;
            if (seen != 0) begin
                n_bad++;
                $display("FAIL R12 strobes on unused code: actual %0d expected 0", seen);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule